// File: doc/BRIEF.md
# Cyclic Level Sequence Generator

This block plays back a short list of output levels, one entry at a time, on a single data bit with an enable beside it. Each entry is low, high or don't-care. A don't-care entry is presented as the enable deasserted with the data bit held low. The list length, its contents, the step period and the first-edge delay are all inputs, and they are expected to stay stable while the block runs.

The block does not step on the system clock. It steps on a separate time-base input that is sampled on every clock. Each change of that input, rising or falling, is one tick. After reset the step counter starts below zero, biased by the step period plus the first-edge delay. It counts up by one per tick. When it reaches the step period, it clears and the list position moves on by one. After the last entry the position wraps to the first, so the pattern repeats forever.

A typical setting is a step period of 2 ticks and a first-edge delay of 1 tick. The time base is assumed to be synchronous to the clock. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `cyclic_level_gen`

## Requirements
- R1: While reset is asserted, and after its release until the first advance, the list position is 0 and the outputs show entry 0.
- R2: A tick is any cycle in which the sampled time base differs from its value on the previous clock edge, whether it rose or fell. Without a tick the outputs do not change.
- R3: The step counter starts at minus (step period + first-edge delay) and moves up by one per tick. The first advance therefore happens on tick number 2*period + delay after reset, counting the first tick as tick 1.
- R4: After each advance the counter restarts at 0. Every later advance happens on the period-th tick after the previous one. A period of 0 advances on every tick.
- R5: When the position is at entry length-1, the next advance goes to entry 0. The position is always below the effective length.
- R6: Entry i uses bit i of the level vector and bit i of the don't-care vector. If don't-care bit i is 1, the outputs are enable 0 and data 0. Otherwise enable is 1 and data equals level bit i.
- R7: A programmed length of 0 acts as a length of 1. A length above MAX_LEN acts as MAX_LEN.
- R8: A tick is sampled on a rising clock edge, and any resulting output change appears right after that same edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_base | input | 1 | Toggling time base; every change is one tick |
| seq_len | input | $clog2(MAX_LEN+1) | Number of list entries in use |
| seq_bits | input | MAX_LEN | Level of each entry, entry i at bit i |
| seq_dc | input | MAX_LEN | Don't-care flag of each entry, entry i at bit i |
| step_period | input | PER_W | Ticks between advances |
| first_delay | input | PER_W | Extra ticks before the first advance |
| lvl_data | output | 1 | Current level, 0 for a don't-care entry |
| lvl_en | output | 1 | 1 unless the current entry is don't-care |

## Verification
A toggle applied between clock edges becomes a tick at the next rising edge, and the new outputs are due right after that edge. The bench therefore checks the outputs one time unit after each toggle, when they must still hold the old entry. It checks them again at the following falling edge, when they must show the advanced entry. Idle stretches with no toggle are checked at falling edges and must show no change. After reset release the bench waits three cycles to cover the two-stage release before it makes the first check.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

  typedef enum logic [1:0] {
    LVL_LO = 2'd0,
    LVL_HI = 2'd1,
    LVL_DC = 2'd2
  } level_e;

  function automatic level_e level_of(input logic bit_val, input logic dc_val);
    if (dc_val)       return LVL_DC;
    else if (bit_val) return LVL_HI;
    else              return LVL_LO;
  endfunction

endpackage

// File: rtl/lsg_rst_sync.sv
module lsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lsg_tick_detect.sv
module lsg_tick_detect (
  input  logic clk,
  input  logic time_base,
  output logic tick
);

  // Sample flop runs through reset so no false tick follows release.
  logic tb_q;

  always_ff @(posedge clk) begin
    tb_q <= time_base;
  end

  assign tick = time_base ^ tb_q;

endmodule

// File: rtl/lsg_step_timer.sv
module lsg_step_timer #(
  parameter int PER_W = 8,
  localparam int CNT_W = PER_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] step_period,
  input  logic [PER_W-1:0] first_delay,
  output logic             adv
);

  // Biased start -(P+D) is folded into a larger first threshold 2P+D.
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    if (first_q)
      thr = (CNT_W'(step_period) << 1) + CNT_W'(first_delay);
    else
      thr = CNT_W'(step_period);
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    first_d = first_q;
    adv     = 1'b0;
    if (tick) begin
      if (cnt_inc >= thr) begin
        cnt_d   = '0;
        first_d = 1'b0;
        adv     = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (tick) begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

endmodule

// File: rtl/lsg_index.sv
module lsg_index #(
  parameter int MAX_LEN = 8,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [LEN_W-1:0] seq_len,
  output logic [LEN_W-1:0] len_eff,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    if (seq_len == '0)
      len_eff = LEN_W'(1);
    else if (seq_len > LEN_W'(MAX_LEN))
      len_eff = LEN_W'(MAX_LEN);
    else
      len_eff = seq_len;
  end

  always_comb begin
    idx_d = idx_q;
    if (LEN_W'(idx_q) >= len_eff - LEN_W'(1))
      idx_d = '0;
    else
      idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (adv) idx_q <= idx_d;
  end

  assign idx = idx_q;

endmodule

// File: rtl/cyclic_level_gen.sv
module cyclic_level_gen #(
  parameter int MAX_LEN = 8,
  parameter int PER_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               time_base,
  input  logic [LEN_W-1:0]   seq_len,
  input  logic [MAX_LEN-1:0] seq_bits,
  input  logic [MAX_LEN-1:0] seq_dc,
  input  logic [PER_W-1:0]   step_period,
  input  logic [PER_W-1:0]   first_delay,
  output logic               lvl_data,
  output logic               lvl_en
);

  import lsg_pkg::*;

  logic             rst_sync_n;
  logic             tick;
  logic             adv;
  logic [LEN_W-1:0] len_eff;
  logic [IDX_W-1:0] idx;
  level_e           entry_lvl [MAX_LEN];
  level_e           cur_lvl;

  lsg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lsg_tick_detect u_tick (
    .clk       (clk),
    .time_base (time_base),
    .tick      (tick)
  );

  lsg_step_timer #(.PER_W(PER_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (tick),
    .step_period (step_period),
    .first_delay (first_delay),
    .adv         (adv)
  );

  lsg_index #(.MAX_LEN(MAX_LEN)) u_index (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv     (adv),
    .seq_len (seq_len),
    .len_eff (len_eff),
    .idx     (idx)
  );

  for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_entry
    assign entry_lvl[gi] = level_of(seq_bits[gi], seq_dc[gi]);
  end

  always_comb begin
    cur_lvl = LVL_DC;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (idx == IDX_W'(i)) cur_lvl = entry_lvl[i];
    end
  end

  assign lvl_data = (cur_lvl == LVL_HI);
  assign lvl_en   = (cur_lvl != LVL_DC);

endmodule

// File: rtl/cyclic_level_gen_chk.sv
module cyclic_level_gen_chk #(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = 4,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               adv,
  input logic [LEN_W-1:0]   len_eff,
  input logic [IDX_W-1:0]   idx,
  input logic [MAX_LEN-1:0] seq_dc,
  input logic               lvl_data,
  input logic               lvl_en
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_index_chk: assert (idx == '0);
    end
  end

  // R2
  adv_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> tick);

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(idx));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    LEN_W'(idx) < len_eff);

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (LEN_W'(idx) == len_eff - LEN_W'(1))) |=> (idx == '0));

  // R6
  dc_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_dc[idx] |-> (!lvl_en && !lvl_data));

  // R7
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_eff >= LEN_W'(1)) && (len_eff <= LEN_W'(MAX_LEN)));

endmodule

bind cyclic_level_gen cyclic_level_gen_chk #(
  .MAX_LEN (MAX_LEN),
  .LEN_W   (LEN_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .adv      (adv),
  .len_eff  (len_eff),
  .idx      (idx),
  .seq_dc   (seq_dc),
  .lvl_data (lvl_data),
  .lvl_en   (lvl_en)
);

// File: tb/tb_cyclic_level_gen.sv
module tb_cyclic_level_gen;

  localparam int MAX_LEN = 8;
  localparam int PER_W   = 8;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic               clk;
  logic               rst_n;
  logic               time_base;
  logic [LEN_W-1:0]   seq_len;
  logic [MAX_LEN-1:0] seq_bits;
  logic [MAX_LEN-1:0] seq_dc;
  logic [PER_W-1:0]   step_period;
  logic [PER_W-1:0]   first_delay;
  logic               lvl_data;
  logic               lvl_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  cyclic_level_gen #(.MAX_LEN(MAX_LEN), .PER_W(PER_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .time_base   (time_base),
    .seq_len     (seq_len),
    .seq_bits    (seq_bits),
    .seq_dc      (seq_dc),
    .step_period (step_period),
    .first_delay (first_delay),
    .lvl_data    (lvl_data),
    .lvl_en      (lvl_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_entry(input int e, input string tag);
    logic exp_d, exp_e;
    exp_e = ~seq_dc[e];
    exp_d = seq_dc[e] ? 1'b0 : seq_bits[e];
    n_cmp++;
    if (lvl_data !== exp_d || lvl_en !== exp_e) begin
      n_bad++;
      $display("FAIL %s: entry %0d got data=%b en=%b expected data=%b en=%b",
               tag, e, lvl_data, lvl_en, exp_d, exp_e);
    end
  endtask

  task automatic run_cfg(input int len, input int p, input int d, input int nticks,
                         input int seed);
    int leff, cnt, idx;
    bit first;
    string tag;
    seq_len     = LEN_W'(len);
    step_period = PER_W'(p);
    first_delay = PER_W'(d);
    seq_bits    = MAX_LEN'(8'hA5 ^ (seed * 37));
    seq_dc      = MAX_LEN'(8'h12 << (seed % 3));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_entry(0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_entry(0, "R1 after release");
    leff  = (len == 0) ? 1 : (len > MAX_LEN ? MAX_LEN : len);
    cnt   = -(p + d);
    idx   = 0;
    first = 1;
    for (int k = 0; k < nticks; k++) begin
      time_base = ~time_base;
      #1;
      check_entry(idx, "R8 before edge");
      @(negedge clk);
      cnt = cnt + 1;
      tag = "R2 no advance";
      if (cnt >= p) begin
        cnt = 0;
        idx = (idx + 1) % leff;
        if (first)         tag = "R3 first advance";
        else if (idx == 0) tag = "R5 wrap";
        else               tag = "R4 later advance";
        if (len == 0 || len > MAX_LEN) tag = {tag, " R7 clamp"};
        first = 0;
      end
      if (seq_dc[idx]) tag = {tag, " R6 dont-care"};
      check_entry(idx, tag);
      if (k % 4 == 3) begin
        repeat (2) @(negedge clk);
        check_entry(idx, "R2 idle hold");
      end
    end
  endtask

  initial begin
    int seed;
    int lens [5];
    lens = '{0, 1, 3, 8, 12};
    time_base = 1'b0;
    rst_n = 1'b0;
    seq_len = '0; seq_bits = '0; seq_dc = '0;
    step_period = '0; first_delay = '0;
    seed = 0;
    // typical setting: period 2, delay 1
    run_cfg(5, 2, 1, 20, 7);
    for (int li = 0; li < 5; li++) begin
      for (int p = 0; p < 4; p++) begin
        for (int d = 0; d < 4; d++) begin
          seed++;
          run_cfg(lens[li], p, d, 2 * p + d + 3 * MAX_LEN, seed);
        end
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule